// File: doc/BRIEF.md
# Wraparound-Aware Timestamp Extender

This block sits behind a queue of time events whose captured values are only 32 bits wide. It widens each event to a 64-bit time value by placing an upper word, kept inside the block, above the 32 captured bits. Two special event kinds on the stream drive that upper word. A wrap event means the 32-bit counter has gone from all ones to zero, so the upper word counts up by one. A midpoint event means the counter has crossed from 0x7FFF_FFFF to 0x8000_0000.

An event can be captured shortly before a wrap and still reach the queue after the wrap event. A wrap event opens a correction window and the next midpoint event closes it. Inside that window, a captured value whose top bit is set must belong to the period before the wrap, so it is widened with the upper word minus one. A captured value whose top bit is clear is widened with the current upper word. Outside the window no correction is applied.

Both edges of the block are valid/ready streams, and the output is a single register stage. A load port writes the upper word directly, for example after the time base has been set. A one-cycle error pulse marks a second wrap event that arrives while a window is still open.

Top module: `tsx_extender`

## Requirements
- R1: After reset, `out_valid` and `err_o` are low, the upper word is zero and the correction window is closed.
- R2: A timestamp event (any `in_type` other than the wrap and midpoint codes) accepted while the window is closed leaves as `{upper, in_ts}`.
- R3: A wrap event (`in_type` = 1) increments the upper word modulo 2^32 and opens the window. It is itself output as `{upper+1, in_ts}`.
- R4: A timestamp accepted inside the window with `in_ts[31]` = 1 leaves as `{upper-1, in_ts}`, computed modulo 2^32.
- R5: A timestamp accepted inside the window with `in_ts[31]` = 0 leaves as `{upper, in_ts}`.
- R6: A midpoint event (`in_type` = 2) is output as `{upper, in_ts}` and closes the window.
- R7: A wrap event accepted while the window is already open raises `err_o` for exactly the following cycle, and the upper word still increments.
- R8: While `load_en` is high, `in_ready` is low. The upper word takes `load_val` and the window closes, so a following timestamp with its top bit set is not corrected.
- R9: While `out_valid` is high and `out_ready` is low, the output type and value hold steady and `in_ready` is low.
- R10: An accepted event appears on `out_valid`/`out_type`/`out_ts` in the cycle after acceptance, with its type passed through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input event present |
| in_ready | output | 1 | Block accepts the input event this cycle |
| in_type | input | 3 | Event kind code |
| in_ts | input | 32 | Captured 32-bit time value |
| load_en | input | 1 | Write `load_val` into the upper word |
| load_val | input | 32 | Value for the upper word |
| out_valid | output | 1 | Output event present |
| out_ready | input | 1 | Downstream accepts the output event |
| out_type | output | 3 | Event kind code, passed through |
| out_ts | output | 64 | Extended 64-bit time value |
| err_o | output | 1 | One-cycle pulse on a wrap event that arrives inside an open window |

## Verification
The hardest case to reach from the ports is a late-queued timestamp that lands inside the correction window while the upper word is at a boundary. If the upper word is zero, the minus-one correction must wrap around to all ones. The stimulus first uses the load port to place the upper word at all ones, then sends a wrap event so the word rolls to zero, then sends a timestamp with its top bit set. A random phase then mixes all three event kinds with stalls on the output side. This drives window transitions and duplicate wraps while the output is held.

// File: rtl/tsx_pkg.sv
package tsx_pkg;
  typedef enum logic [1:0] {
    EVK_TS   = 2'd0,
    EVK_WRAP = 2'd1,
    EVK_MID  = 2'd2
  } evk_e;
endpackage

// File: rtl/tsx_classify.sv
module tsx_classify #(
  parameter int TYPE_W    = 3,
  parameter int WRAP_CODE = 1,
  parameter int MID_CODE  = 2
) (
  input  logic [TYPE_W-1:0] type_i,
  output tsx_pkg::evk_e     kind_o
);
  localparam logic [TYPE_W-1:0] WRAP_V = TYPE_W'(WRAP_CODE);
  localparam logic [TYPE_W-1:0] MID_V  = TYPE_W'(MID_CODE);

  always_comb begin
    if (type_i == WRAP_V)     kind_o = tsx_pkg::EVK_WRAP;
    else if (type_i == MID_V) kind_o = tsx_pkg::EVK_MID;
    else                      kind_o = tsx_pkg::EVK_TS;
  end
endmodule

// File: rtl/tsx_epoch_track.sv
module tsx_epoch_track #(
  parameter int UP_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            acc_i,
  input  tsx_pkg::evk_e   kind_i,
  input  logic            load_en_i,
  input  logic [UP_W-1:0] load_val_i,
  output logic [UP_W-1:0] upper_o,
  output logic            win_o,
  output logic            err_o
);
  logic [UP_W-1:0] upper_q;
  logic            win_q;
  logic            err_q;
  logic            dup_wrap;

  // a wrap arriving while the previous window is still open
  assign dup_wrap = acc_i && (kind_i == tsx_pkg::EVK_WRAP) && win_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      upper_q <= '0;
      win_q   <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      err_q <= dup_wrap;
      if (load_en_i) begin
        upper_q <= load_val_i;
        win_q   <= 1'b0;
      end else if (acc_i) begin
        unique case (kind_i)
          tsx_pkg::EVK_WRAP: begin
            upper_q <= upper_q + UP_W'(1);
            win_q   <= 1'b1;
          end
          tsx_pkg::EVK_MID: win_q <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  assign upper_o = upper_q;
  assign win_o   = win_q;
  assign err_o   = err_q;
endmodule

// File: rtl/tsx_compose.sv
module tsx_compose #(
  parameter int UP_W = 32,
  parameter int TS_W = 32
) (
  input  tsx_pkg::evk_e        kind_i,
  input  logic [UP_W-1:0]      upper_i,
  input  logic                 win_i,
  input  logic [TS_W-1:0]      ts_i,
  output logic [UP_W+TS_W-1:0] ext_o
);
  logic [UP_W-1:0] sel;

  always_comb begin
    unique case (kind_i)
      tsx_pkg::EVK_WRAP: sel = upper_i + UP_W'(1);
      tsx_pkg::EVK_MID:  sel = upper_i;
      default:           sel = (win_i && ts_i[TS_W-1]) ? upper_i - UP_W'(1) : upper_i;
    endcase
  end

  assign ext_o = {sel, ts_i};
endmodule

// File: rtl/tsx_out_reg.sv
module tsx_out_reg #(
  parameter int W = 67
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_ready
);
  logic         v_q;
  logic [W-1:0] d_q;

  assign in_ready = !v_q || out_ready;

  always_ff @(posedge clk) begin
    if (rst) v_q <= 1'b0;
    else if (in_ready) v_q <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) d_q <= in_data;
  end

  assign out_valid = v_q;
  assign out_data  = d_q;
endmodule

// File: rtl/tsx_extender.sv
module tsx_extender #(
  parameter int TYPE_W    = 3,
  parameter int TS_W      = 32,
  parameter int UP_W      = 32,
  parameter int WRAP_CODE = 1,
  parameter int MID_CODE  = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [TYPE_W-1:0]    in_type,
  input  logic [TS_W-1:0]      in_ts,
  input  logic                 load_en,
  input  logic [UP_W-1:0]      load_val,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [TYPE_W-1:0]    out_type,
  output logic [UP_W+TS_W-1:0] out_ts,
  output logic                 err_o
);
  localparam int EXT_W = UP_W + TS_W;
  localparam int PAY_W = TYPE_W + EXT_W;

  tsx_pkg::evk_e   kind;
  logic [UP_W-1:0] upper_q;
  logic            win_q;
  logic [EXT_W-1:0] ext;
  logic            stage_ready;
  logic            acc;
  logic [PAY_W-1:0] pay_out;

  assign in_ready = stage_ready && !load_en;
  assign acc      = in_valid && in_ready;

  tsx_classify #(.TYPE_W(TYPE_W), .WRAP_CODE(WRAP_CODE), .MID_CODE(MID_CODE)) cls_i (
    .type_i (in_type),
    .kind_o (kind)
  );

  tsx_epoch_track #(.UP_W(UP_W)) trk_i (
    .clk        (clk),
    .rst        (rst),
    .acc_i      (acc),
    .kind_i     (kind),
    .load_en_i  (load_en),
    .load_val_i (load_val),
    .upper_o    (upper_q),
    .win_o      (win_q),
    .err_o      (err_o)
  );

  tsx_compose #(.UP_W(UP_W), .TS_W(TS_W)) cmp_i (
    .kind_i  (kind),
    .upper_i (upper_q),
    .win_i   (win_q),
    .ts_i    (in_ts),
    .ext_o   (ext)
  );

  tsx_out_reg #(.W(PAY_W)) oreg_i (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid && !load_en),
    .in_data   ({in_type, ext}),
    .in_ready  (stage_ready),
    .out_valid (out_valid),
    .out_data  (pay_out),
    .out_ready (out_ready)
  );

  assign out_type = pay_out[PAY_W-1 -: TYPE_W];
  assign out_ts   = pay_out[EXT_W-1:0];
endmodule

// File: rtl/tsx_extender_chk.sv
module tsx_extender_chk #(
  parameter int TYPE_W    = 3,
  parameter int TS_W      = 32,
  parameter int UP_W      = 32,
  parameter int WRAP_CODE = 1,
  parameter int MID_CODE  = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic [TYPE_W-1:0]    in_type,
  input logic [TS_W-1:0]      in_ts,
  input logic                 load_en,
  input logic [UP_W-1:0]      load_val,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic [TYPE_W-1:0]    out_type,
  input logic [UP_W+TS_W-1:0] out_ts,
  input logic                 err_o,
  input logic [UP_W-1:0]      upper,
  input logic                 win
);
  logic acc, is_wrap, is_mid;
  assign acc     = in_valid && in_ready;
  assign is_wrap = in_type == TYPE_W'(WRAP_CODE);
  assign is_mid  = in_type == TYPE_W'(MID_CODE);

  assert_wrap_incr_R3: assert property (@(posedge clk) disable iff (rst)
    acc && is_wrap |=> upper == $past(upper) + UP_W'(1) && win);

  assert_late_fix_R4: assert property (@(posedge clk) disable iff (rst)
    acc && !is_wrap && !is_mid && win && in_ts[TS_W-1]
    |=> out_ts[UP_W+TS_W-1:TS_W] == $past(upper) - UP_W'(1));

  assert_mid_close_R6: assert property (@(posedge clk) disable iff (rst)
    acc && is_mid |=> !win);

  assert_dup_err_R7: assert property (@(posedge clk) disable iff (rst)
    acc && is_wrap && win |=> err_o);

  assert_load_block_R8: assert property (@(posedge clk) disable iff (rst)
    load_en |-> !in_ready);

  assert_load_take_R8: assert property (@(posedge clk) disable iff (rst)
    load_en |=> upper == $past(load_val) && !win);

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_ts) && $stable(out_type));

  assert_latency_R10: assert property (@(posedge clk) disable iff (rst)
    acc |=> out_valid && out_type == $past(in_type));
endmodule

bind tsx_extender tsx_extender_chk #(
  .TYPE_W(TYPE_W), .TS_W(TS_W), .UP_W(UP_W), .WRAP_CODE(WRAP_CODE), .MID_CODE(MID_CODE)
) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_type(in_type),
  .in_ts(in_ts), .load_en(load_en), .load_val(load_val), .out_valid(out_valid),
  .out_ready(out_ready), .out_type(out_type), .out_ts(out_ts), .err_o(err_o),
  .upper(upper_q), .win(win_q)
);

// File: tb/tsx_extender_tb_top.sv
module tsx_extender_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_type = '0;
  logic [31:0] in_ts = '0;
  logic        load_en = 1'b0;
  logic [31:0] load_val = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [2:0]  out_type;
  logic [63:0] out_ts;
  logic        err_o;

  always #2 clk = ~clk;

  tsx_extender dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_type(in_type),
    .in_ts(in_ts), .load_en(load_en), .load_val(load_val), .out_valid(out_valid),
    .out_ready(out_ready), .out_type(out_type), .out_ts(out_ts), .err_o(err_o)
  );

  int n_chk = 0;
  int n_fail = 0;

  // reference model state
  logic [31:0] m_up = '0;
  bit          m_win = 0;
  bit          m_err = 0;
  bit          m_post_load = 0;
  logic [66:0] qv[$];
  string       qt[$];

  task automatic chk(input string tag, input logic [67:0] act, input logic [67:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_accept(input logic [2:0] t, input logic [31:0] d);
    string tag;
    logic [31:0] u;
    if (t == 3'd1) begin
      m_err = m_win;
      tag = m_win ? "R7 duplicate wrap" : "R3 wrap";
      m_up = m_up + 32'd1;
      m_win = 1;
      u = m_up;
    end else if (t == 3'd2) begin
      tag = "R6 midpoint";
      u = m_up;
      m_win = 0;
    end else if (m_win && d[31]) begin
      tag = "R4 late capture";
      u = m_up - 32'd1;
    end else if (m_win) begin
      tag = "R5 window msb0";
      u = m_up;
    end else begin
      tag = m_post_load ? "R8 after load" : "R2 plain";
      u = m_up;
    end
    m_post_load = 0;
    qv.push_back({t, u, d});
    qt.push_back(tag);
  endtask

  task automatic cyc(input logic v, input logic [2:0] t, input logic [31:0] d,
                     input logic rdy, input logic ld, input logic [31:0] lv, output bit acc);
    bit fire;
    logic [67:0] act;
    in_valid = v; in_type = t; in_ts = d; out_ready = rdy; load_en = ld; load_val = lv;
    #1;
    acc  = v && in_ready;
    fire = out_valid && rdy;
    if (ld) chk("R8 in_ready during load", {67'd0, in_ready}, 68'd0);
    if (out_valid && !rdy) chk("R9 in_ready during stall", {67'd0, in_ready}, 68'd0);
    @(posedge clk);
    if (fire) begin void'(qv.pop_front()); void'(qt.pop_front()); end
    m_err = 0;
    if (ld) begin m_up = lv; m_win = 0; m_post_load = 1; end
    else if (acc) model_accept(t, d);
    @(negedge clk);
    act = {out_valid, out_type, out_ts};
    if (qv.size() > 0) chk(qt[0], act, {1'b1, qv[0]});
    else chk("R10 idle output", act, {1'b0, act[66:0]});
    chk("R7 error pulse", {67'd0, err_o}, {67'd0, m_err});
  endtask

  task automatic send(input logic [2:0] t, input logic [31:0] d, input int stall);
    bit a = 0;
    int s = stall;
    while (!a) begin
      cyc(1'b1, t, d, (s > 0) ? 1'b0 : 1'b1, 1'b0, 32'd0, a);
      s--;
    end
  endtask

  task automatic idle(input int n);
    bit a;
    for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, 32'd0, 1'b1, 1'b0, 32'd0, a);
  endtask

  task automatic load(input logic [31:0] v);
    bit a;
    cyc(1'b0, 3'd0, 32'd0, 1'b1, 1'b1, v, a);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset valid", {67'd0, out_valid}, 68'd0);
    chk("R1 reset err", {67'd0, err_o}, 68'd0);
    send(3'd0, 32'h1234_5678, 0);        // R1 upper zero, R2
    idle(1);
    send(3'd1, 32'h0000_0000, 0);        // R3
    send(3'd0, 32'hEFFF_FFF0, 0);        // R4
    send(3'd0, 32'h3800_1000, 0);        // R5
    send(3'd2, 32'h8000_0000, 0);        // R6
    send(3'd0, 32'h8000_FFFF, 0);        // R2 after close
    send(3'd1, 32'h0, 0);
    send(3'd1, 32'h0, 0);                // R7
    send(3'd0, 32'hF000_0000, 0);
    send(3'd2, 32'h8000_0000, 0);
    idle(2);
    load(32'hFFFF_FFFF);                 // R8
    send(3'd1, 32'h0, 0);                // R3 wrap to zero
    send(3'd0, 32'hFFFF_FFFF, 0);        // R4 zero minus one
    send(3'd2, 32'h8000_0000, 0);
    send(3'd1, 32'h0, 0);
    load(32'd5);                         // R8 closes window
    send(3'd0, 32'h9000_0000, 0);
    send(3'd5, 32'h1111_1111, 0);
    send(3'd0, 32'hAAAA_0000, 3);        // R9 stalled
    send(3'd1, 32'h0, 4);
    send(3'd0, 32'hC000_0001, 2);
    idle(2);
    for (int i = 0; i < 400; i++) begin
      bit a;
      int r = $urandom % 16;
      logic [2:0] t = (r < 2) ? 3'd1 : (r < 4) ? 3'd2 : 3'($urandom % 8);
      if (r == 15) load($urandom);
      else cyc(($urandom % 4) != 0, t, $urandom, ($urandom % 3) != 0, 1'b0, 32'd0, a);
    end
    idle(3);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule